// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the memory address for every beat of a four-beat burst in a pipelined synchronous memory. A single start/advance control drives it: when that control is low the block captures a fresh external address and the read/write direction that comes with it, and when it is high the block steps an internal two-bit beat counter. The low two address bits of each beat follow either a wrapping linear order or an XOR-interleaved order, chosen by an order-select input; the bits above them stay fixed for the whole burst.

A chip-select-valid input, formed outside from the device enables, gates the start of a burst: a start cycle without it ends any burst in progress and leaves the captured address untouched. A clock enable freezes all state while it is low. The outputs are the current beat address, the direction of the burst and a flag saying a burst is active, ready to feed the array and data pipeline that sit beside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and after its synchronous release until the first start, `beat_valid` is 0, `beat_wr` is 0 and `beat_addr` is all zeros.
- R2: A clock edge with `clk_en`=1, `ld_n`=0 and `sel_ok`=1 makes `beat_addr` equal `ext_addr`, `beat_wr` equal `wr_in` and `beat_valid` 1 after that edge.
- R3: With `order_sel`=0 (linear) and k advances since the start, the low two bits of `beat_addr` equal (start low bits + k) mod 4.
- R4: With `order_sel`=1 (interleaved) and k advances since the start, the low two bits of `beat_addr` equal start low bits XOR (k mod 4).
- R5: Bits above bit 1 of `beat_addr` do not change on advance cycles.
- R6: After four advances the beat address returns to the start address, and the sequence repeats.
- R7: A clock edge with `clk_en`=1, `ld_n`=0 and `sel_ok`=0 clears `beat_valid`; `beat_addr` and `beat_wr` keep their previous values.
- R8: A clock edge with `clk_en`=0 changes none of `beat_addr`, `beat_wr`, `beat_valid`, whatever the other inputs are.
- R9: On advance cycles (`ld_n`=1) `wr_in` is ignored; `beat_wr` keeps the direction captured at the start.
- R10: An advance with no active burst leaves `beat_valid` at 0 and `beat_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Clock enable; 0 holds all state |
| ld_n | input | 1 | 0 = start a burst from `ext_addr`, 1 = advance one beat |
| sel_ok | input | 1 | 1 when every device enable is active |
| order_sel | input | 1 | 0 = linear beat order, 1 = interleaved beat order |
| ext_addr | input | ADDR_W | External start address |
| wr_in | input | 1 | Direction of a new burst, 1 = write |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_wr | output | 1 | Direction of the current burst |
| beat_valid | output | 1 | A burst is active |

## Verification
A wrong beat count shows in the low two bits of `beat_addr` on the very next advance, and a count that fails to wrap shows on the fifth beat, when the address should be back at the start. A captured base or direction that drifts shows at once as upper address bits or `beat_wr` moving during advances, and a lost active flag shows as `beat_valid` falling while the bench still expects a burst. Since every output is registered state or a combination of it, each internal fault is visible one clock edge after the stimulus that causes it.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
  parameter int W = burst_pkg::BEAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] STEP = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ce) begin
      if (clr)      cnt_d = '0;
      else if (inc) cnt_d = cnt_q + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CNT_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ce && inc && !clr |=> cnt_q == $past(cnt_q) + STEP); // R6
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/beat_seq.sv
module beat_seq #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = burst_pkg::BEAT_W
) (
  input  logic [ADDR_W-1:0]   base,
  input  logic [BEAT_W-1:0]   cnt,
  input  burst_pkg::order_e   order,
  output logic [ADDR_W-1:0]   addr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] xor_lo;
  logic [BEAT_W-1:0] sel_lo;

  always_comb begin
    lin_lo = base[BEAT_W-1:0] + cnt;
    xor_lo = base[BEAT_W-1:0] ^ cnt;
    sel_lo = (order == burst_pkg::ORD_XOR) ? xor_lo : lin_lo;
  end

  generate
    if (HI_W > 0) begin : g_hi
      assign addr = {base[ADDR_W-1:BEAT_W], sel_lo};
    end else begin : g_lo_only
      assign addr = sel_lo[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              ld_n,
  input  logic              sel_ok,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              wr_in,
  output logic [ADDR_W-1:0] base,
  output logic              dir,
  output logic              active,
  output logic              cnt_clr,
  output logic              cnt_inc
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic              dir_q, dir_d;
  logic              act_q, act_d;
  logic              start_ok;
  logic              start_bad;

  always_comb begin
    start_ok  = !ld_n && sel_ok;
    start_bad = !ld_n && !sel_ok;
    base_d    = base_q;
    dir_d     = dir_q;
    act_d     = act_q;
    if (ce) begin
      if (start_ok) begin
        base_d = ext_addr;
        dir_d  = wr_in;
        act_d  = 1'b1;
      end else if (start_bad) begin
        act_d  = 1'b0;
      end
    end
    cnt_clr = start_ok;
    cnt_inc = ld_n && act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      dir_q  <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      dir_q  <= dir_d;
      act_q  <= act_d;
    end
  end

  assign base   = base_q;
  assign dir    = dir_q;
  assign active = act_q;

  AST_START_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ce && !ld_n && sel_ok |=> act_q && base_q == $past(ext_addr) && dir_q == $past(wr_in)); // R2
  AST_DESEL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ce && !ld_n && !sel_ok |=> !act_q && $stable(base_q) && $stable(dir_q)); // R7
  AST_ADV_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> $stable(dir_q) && $stable(base_q)); // R9
  AST_IDLE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n && !act_q |=> !act_q); // R10
  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(act_q) && $stable(base_q) && $stable(dir_q)); // R8
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W    = 18,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              ld_n,
  input  logic              sel_ok,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              wr_in,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_wr,
  output logic              beat_valid
);
  localparam int BEAT_W = burst_pkg::BEAT_W;

  logic              rst_int_n;
  logic [ADDR_W-1:0] base;
  logic              dir;
  logic              active;
  logic              cnt_clr;
  logic              cnt_inc;
  logic [BEAT_W-1:0] cnt;
  burst_pkg::order_e order;

  assign order = burst_pkg::order_e'(order_sel);

  rst_sync #(.STAGES(RST_STAGE)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  burst_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ce       (clk_en),
    .ld_n     (ld_n),
    .sel_ok   (sel_ok),
    .ext_addr (ext_addr),
    .wr_in    (wr_in),
    .base     (base),
    .dir      (dir),
    .active   (active),
    .cnt_clr  (cnt_clr),
    .cnt_inc  (cnt_inc)
  );

  beat_counter #(.W(BEAT_W)) i_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ce    (clk_en),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (cnt)
  );

  beat_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_seq (
    .base  (base),
    .cnt   (cnt),
    .order (order),
    .addr  (beat_addr)
  );

  assign beat_wr    = dir;
  assign beat_valid = active;

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_int_n)
    ld_n |=> beat_addr[ADDR_W-1:BEAT_W] == $past(beat_addr[ADDR_W-1:BEAT_W])); // R5
  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_int_n)
    clk_en && !ld_n && sel_ok |=> beat_addr == $past(ext_addr)); // R2
  AST_IDLE_VALID_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    clk_en && ld_n && !beat_valid |=> !beat_valid && $stable(beat_addr) || $changed(order_sel)); // R10
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clk_en, ld_n, sel_ok, order_sel, wr_in;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] beat_addr;
  logic          beat_wr, beat_valid;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic          m_dir, m_act;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ld_n(ld_n), .sel_ok(sel_ok),
    .order_sel(order_sel), .ext_addr(ext_addr), .wr_in(wr_in),
    .beat_addr(beat_addr), .beat_wr(beat_wr), .beat_valid(beat_valid)
  );

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] k, logic m);
    logic [1:0] lo;
    lo = m ? (b[1:0] ^ k) : (b[1:0] + k);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp, string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, 32'(beat_addr), 32'(exp_addr(m_base, m_cnt, order_sel)), "beat_addr");
    check(tag, 32'(beat_wr), 32'(m_dir), "beat_wr");
    check(tag, 32'(beat_valid), 32'(m_act), "beat_valid");
  endtask

  task automatic step(logic ce, logic ld, logic sel, logic m, logic [AW-1:0] a, logic w, string tag);
    @(negedge clk);
    clk_en = ce; ld_n = ld; sel_ok = sel; order_sel = m; ext_addr = a; wr_in = w;
    @(posedge clk);
    if (ce) begin
      if (!ld) begin
        if (sel) begin m_base = a; m_cnt = 2'd0; m_dir = w; m_act = 1'b1; end
        else m_act = 1'b0;
      end else if (m_act) m_cnt = m_cnt + 2'd1;
    end
    #1;
    check_all(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] st;
    rst_n = 1'b0; clk_en = 1'b0; ld_n = 1'b1; sel_ok = 1'b0; order_sel = 1'b0;
    ext_addr = '0; wr_in = 1'b0;
    m_base = '0; m_cnt = 2'd0; m_dir = 1'b0; m_act = 1'b0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");

    // R10: advance with no burst active
    step(1, 1, 1, 0, 18'h2_5555, 1, "R10");
    step(1, 1, 1, 0, 18'h1_1111, 0, "R10");

    // R2, R3, R6, R9: linear burst from low bits 2, wr_in toggled on advances
    st = 18'h3_0002;
    step(1, 0, 1, 0, st, 1, "R2");
    for (int k = 1; k <= 8; k++) begin
      step(1, 1, 0, 0, 18'h0_0000, k[0], "R3");
      check("R5", 32'(beat_addr[AW-1:2]), 32'(st[AW-1:2]), "upper bits");
      check("R9", 32'(beat_wr), 32'd1, "beat_wr");
      if (k == 4 || k == 8) check("R6", 32'(beat_addr), 32'(st), "wrapped addr");
    end

    // R4: interleaved burst from low bits 1: 1,0,3,2
    st = 18'h0_ABC5;
    step(1, 0, 1, 1, st, 0, "R2");
    step(1, 1, 1, 1, '0, 1, "R4");
    check("R4", 32'(beat_addr[1:0]), 32'd0, "xor beat1");
    step(1, 1, 1, 1, '0, 1, "R4");
    check("R4", 32'(beat_addr[1:0]), 32'd3, "xor beat2");
    step(1, 1, 1, 1, '0, 1, "R4");
    check("R4", 32'(beat_addr[1:0]), 32'd2, "xor beat3");
    step(1, 1, 1, 1, '0, 1, "R6");
    check("R6", 32'(beat_addr), 32'(st), "xor wrap");

    // R8: clock enable low with disruptive inputs
    step(1, 1, 1, 1, '0, 0, "R4");
    for (int k = 0; k < 3; k++) begin
      step(0, k[0], 1, 1, 18'h3_FFFF, 1, "R8");
    end

    // R7: deselect on start cycle
    step(1, 0, 0, 1, 18'h1_2340, 1, "R7");
    check("R7", 32'(beat_valid), 32'd0, "beat_valid");
    step(1, 1, 1, 1, '0, 0, "R10");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic ce, ld, sel, m, w;
      logic [AW-1:0] a;
      string tag;
      ce  = ($urandom_range(99) < 85);
      ld  = ($urandom_range(99) >= 30);
      sel = ($urandom_range(99) < 80);
      m   = (i / 64) % 2 == 1;
      w   = 1'($urandom);
      a   = AW'($urandom);
      if (!ce)             tag = "R8";
      else if (!ld && !sel) tag = "R7";
      else if (!ld)        tag = "R2";
      else if (!m_act)     tag = "R10";
      else if (m)          tag = "R4";
      else                 tag = "R3";
      step(ce, ld, sel, m, a, w, tag);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule